// File: doc/BRIEF.md
# Transmit Packet Buffer Byte Sequencer

This block turns one packet held in a 32-bit-wide buffer RAM into a byte stream for the transmit encoder. A start pulse latches the mode, the payload length, a packed 24-bit configuration word and a 64-bit timestamp. The block first reads the physical-layer header words and presents the rate/length field and, in high-throughput mode, the six-byte high-throughput signal field. It then streams the MAC payload found at buffer byte 16 onward.

While streaming, payload bytes inside a programmable byte window are replaced with timestamp bytes. The last four payload bytes are placeholders. They are never fetched and go out as the CRC-32 frame check sequence computed over every byte emitted before them, patched bytes included. The RAM has a one-cycle read latency and sits outside the block. Payload lengths of 4 and more are supported.

Top module: `txbuf_byte_seq`

## Requirements
- R1: After reset, busy, hdr_valid, out_valid, out_last and ram_rd are all low.
- R2: The configuration word is decoded as follows: buffer index in bits [3:0], window start in bits [9:4], window end in bits [15:10], word offset in bits [23:16]. Word k of the packet is read at ram_addr = {index, (offset + k) mod 2^BUF_AW}. Buffer byte 4k+n is bits [8n+7:8n] of word k.
- R3: In legacy mode (mode_ht=0), sig_field holds buffer bytes 0..2, with byte n at bits [8n+7:8n], and htsig_field is zero. Bytes 3..15 are not used.
- R4: In high-throughput mode (mode_ht=1), sig_field holds bytes 0..2 as in R3, and htsig_field holds bytes 3..8, with byte 3+n at bits [8n+7:8n].
- R5: For payload length L, exactly L bytes are emitted. Byte i is buffer byte 16+i unless R6 or R7 applies, and out_last is high only on byte L-1.
- R6: Bytes L-4..L-1 carry the frame check sequence, least significant byte first, and ignore the buffer contents. The sequence is the reflected CRC-32 with polynomial 0x04C11DB7, an all-ones start value and final inversion, taken over the emitted bytes 0..L-5.
- R7: A byte i with start <= i <= end and i < L-4 is replaced by timestamp byte ((i - start) mod 8), where byte j is bits [8j+7:8j]. If start > end, no byte is replaced. Replaced bytes enter the CRC.
- R8: While out_valid is high and out_ready is low, out_data and out_last hold and out_valid stays high.
- R9: A start while busy is ignored. All packet parameters are latched at an accepted start, so later input changes do not affect the packet.
- R10: hdr_valid rises once the header is captured and before the first byte is offered. It stays high with the fields held until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a packet (accepted only when idle) |
| mode_ht | input | 1 | 0 legacy header layout, 1 high-throughput layout |
| pay_len | input | LEN_W | Payload length in bytes including the four check bytes |
| cfg_word | input | 24 | Buffer index, timestamp window, word offset |
| ts_value | input | TS_W | Timestamp to patch into the window |
| ram_rd | output | 1 | RAM read strobe |
| ram_addr | output | IDX_W+BUF_AW | RAM word address |
| ram_rdata | input | 32 | RAM read data, one cycle after ram_rd |
| busy | output | 1 | Packet in progress |
| hdr_valid | output | 1 | Header fields valid |
| sig_field | output | 24 | Rate/length header field |
| htsig_field | output | 48 | High-throughput signal field |
| out_valid | output | 1 | Byte offered |
| out_data | output | 8 | Byte value |
| out_last | output | 1 | Final byte of the packet |
| out_ready | input | 1 | Consumer accepts the byte |

## Verification
Three situations are hardest to reach. The first is a start pulse that lands in the middle of a stalled packet. The second is a backpressure stall on the byte where the stream moves from data to check bytes. The third is a timestamp window that runs past the end of the data bytes into the check bytes. The stimulus covers them in two ways. Random per-cycle ready densities are applied across random lengths, windows and buffer locations. Directed packets add the length-4 case (check bytes only, expected zero), a window wider than eight bytes that wraps the timestamp, a window straddling the check bytes, an empty window, and an injected start halfway through a packet with the inputs changed underneath it.

// File: rtl/txseq_pkg.sv
package txseq_pkg;

    localparam logic [31:0] FCS_POLY = 32'h04C11DB7;

    function automatic logic [31:0] reflect32(input logic [31:0] v);
        logic [31:0] r;
        for (int i = 0; i < 32; i++) begin
            r[i] = v[31-i];
        end
        return r;
    endfunction

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_HREQ = 3'd1,
        ST_HCAP = 3'd2,
        ST_PREQ = 3'd3,
        ST_PCAP = 3'd4,
        ST_SEND = 3'd5
    } seq_state_e;

endpackage

// File: rtl/txseq_crc_step.sv
module txseq_crc_step #(
    parameter logic [31:0] POLY = txseq_pkg::FCS_POLY
) (
    input  logic [31:0] crc_in,
    input  logic [7:0]  din,
    output logic [31:0] crc_out
);
    localparam logic [31:0] RPOLY = txseq_pkg::reflect32(POLY);

    logic [31:0] c;

    // Reflected form: data enters LSB first.
    always_comb begin
        c = crc_in;
        for (int b = 0; b < 8; b++) begin
            if (c[0] ^ din[b]) begin
                c = (c >> 1) ^ RPOLY;
            end else begin
                c = c >> 1;
            end
        end
        crc_out = c;
    end
endmodule

// File: rtl/txseq_ts_patch.sv
module txseq_ts_patch #(
    parameter int LEN_W = 12,
    parameter int PTR_W = 6,
    parameter int TS_W  = 64
) (
    input  logic [LEN_W-1:0] idx,
    input  logic [PTR_W-1:0] win_lo,
    input  logic [PTR_W-1:0] win_hi,
    input  logic [TS_W-1:0]  ts,
    input  logic [7:0]       raw,
    output logic [7:0]       dout
);
    localparam int TS_BYTES = TS_W / 8;
    localparam int SEL_W    = $clog2(TS_BYTES);

    logic [LEN_W-1:0] lo_x;
    logic [LEN_W-1:0] hi_x;
    logic             hit;
    logic [SEL_W-1:0] sel;

    assign lo_x = LEN_W'(win_lo);
    assign hi_x = LEN_W'(win_hi);
    // An inverted window (lo > hi) never hits.
    assign hit  = (idx >= lo_x) && (idx <= hi_x);
    assign sel  = idx[SEL_W-1:0] - win_lo[SEL_W-1:0];
    assign dout = hit ? ts[{sel, 3'b000} +: 8] : raw;
endmodule

// File: rtl/txseq_addr.sv
module txseq_addr #(
    parameter int IDX_W  = 4,
    parameter int OFS_W  = 8,
    parameter int BUF_AW = 10
) (
    input  logic [IDX_W-1:0]        buf_idx,
    input  logic [OFS_W-1:0]        ofs,
    input  logic [BUF_AW-1:0]       wrd,
    output logic [IDX_W+BUF_AW-1:0] addr
);
    logic [BUF_AW-1:0] inbuf;

    assign inbuf = BUF_AW'(ofs) + wrd;
    assign addr  = {buf_idx, inbuf};
endmodule

// File: rtl/txbuf_byte_seq.sv
module txbuf_byte_seq
    import txseq_pkg::*;
#(
    parameter int LEN_W  = 12,
    parameter int BUF_AW = 10,
    parameter int IDX_W  = 4,
    parameter int OFS_W  = 8,
    parameter int PTR_W  = 6,
    parameter int TS_W   = 64
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic                     mode_ht,
    input  logic [LEN_W-1:0]         pay_len,
    input  logic [IDX_W+2*PTR_W+OFS_W-1:0] cfg_word,
    input  logic [TS_W-1:0]          ts_value,
    output logic                     ram_rd,
    output logic [IDX_W+BUF_AW-1:0]  ram_addr,
    input  logic [31:0]              ram_rdata,
    output logic                     busy,
    output logic                     hdr_valid,
    output logic [23:0]              sig_field,
    output logic [47:0]              htsig_field,
    output logic                     out_valid,
    output logic [7:0]               out_data,
    output logic                     out_last,
    input  logic                     out_ready
);
    // Configuration word field positions (a neighbour packs this word).
    localparam int IDX_LSB = 0;
    localparam int LO_LSB  = IDX_LSB + IDX_W;
    localparam int HI_LSB  = LO_LSB + PTR_W;
    localparam int OFS_LSB = HI_LSB + PTR_W;
    localparam int PAY_WORD0 = 4;   // payload starts at buffer byte 16

    typedef struct packed {
        seq_state_e       st;
        logic             ht;
        logic [LEN_W-1:0] len;
        logic [IDX_W-1:0] bidx;
        logic [OFS_W-1:0] ofs;
        logic [PTR_W-1:0] lo;
        logic [PTR_W-1:0] hi;
        logic [TS_W-1:0]  ts;
        logic [1:0]       hw;
        logic [LEN_W-1:0] idx;
        logic [31:0]      word;
        logic [31:0]      crc;
        logic             hv;
        logic [23:0]      sig;
        logic [47:0]      htsig;
    } seq_t;

    seq_t s_d, s_q;

    logic [LEN_W-1:0]  data_end;
    logic [LEN_W-1:0]  last_idx;
    logic              is_fcs;
    logic [1:0]        lane;
    logic [1:0]        fsel;
    logic [7:0]        raw_byte;
    logic [7:0]        pay_byte;
    logic [31:0]       fcs;
    logic [31:0]       crc_nx;
    logic [BUF_AW-1:0] rd_wrd;

    assign data_end = s_q.len - LEN_W'(4);
    assign last_idx = s_q.len - LEN_W'(1);
    assign is_fcs   = s_q.idx >= data_end;
    assign lane     = s_q.idx[1:0];
    assign fsel     = s_q.idx[1:0] - s_q.len[1:0];
    assign raw_byte = s_q.word[{lane, 3'b000} +: 8];
    assign fcs      = ~s_q.crc;

    txseq_ts_patch #(.LEN_W(LEN_W), .PTR_W(PTR_W), .TS_W(TS_W)) u_ts (
        .idx    (s_q.idx),
        .win_lo (s_q.lo),
        .win_hi (s_q.hi),
        .ts     (s_q.ts),
        .raw    (raw_byte),
        .dout   (pay_byte)
    );

    txseq_crc_step #(.POLY(FCS_POLY)) u_crc (
        .crc_in  (s_q.crc),
        .din     (pay_byte),
        .crc_out (crc_nx)
    );

    always_comb begin
        if (s_q.st == ST_HREQ) begin
            rd_wrd = BUF_AW'(s_q.hw);
        end else begin
            rd_wrd = BUF_AW'(PAY_WORD0) + BUF_AW'(s_q.idx[LEN_W-1:2]);
        end
    end

    txseq_addr #(.IDX_W(IDX_W), .OFS_W(OFS_W), .BUF_AW(BUF_AW)) u_addr (
        .buf_idx (s_q.bidx),
        .ofs     (s_q.ofs),
        .wrd     (rd_wrd),
        .addr    (ram_addr)
    );

    // Next-state logic
    always_comb begin
        s_d = s_q;
        unique case (s_q.st)
            ST_IDLE: begin
                if (start) begin
                    s_d.st    = ST_HREQ;
                    s_d.ht    = mode_ht;
                    s_d.len   = pay_len;
                    s_d.bidx  = cfg_word[IDX_LSB +: IDX_W];
                    s_d.lo    = cfg_word[LO_LSB +: PTR_W];
                    s_d.hi    = cfg_word[HI_LSB +: PTR_W];
                    s_d.ofs   = cfg_word[OFS_LSB +: OFS_W];
                    s_d.ts    = ts_value;
                    s_d.hw    = 2'd0;
                    s_d.idx   = '0;
                    s_d.crc   = '1;
                    s_d.hv    = 1'b0;
                    s_d.sig   = '0;
                    s_d.htsig = '0;
                end
            end
            ST_HREQ: s_d.st = ST_HCAP;
            ST_HCAP: begin
                case (s_q.hw)
                    2'd0: begin
                        s_d.sig = ram_rdata[23:0];
                        if (s_q.ht) s_d.htsig[7:0] = ram_rdata[31:24];
                    end
                    2'd1:    s_d.htsig[39:8]  = ram_rdata;
                    default: s_d.htsig[47:40] = ram_rdata[7:0];
                endcase
                if (!s_q.ht || s_q.hw == 2'd2) begin
                    s_d.hv = 1'b1;
                    s_d.st = (s_q.len > LEN_W'(4)) ? ST_PREQ : ST_SEND;
                end else begin
                    s_d.hw = s_q.hw + 2'd1;
                    s_d.st = ST_HREQ;
                end
            end
            ST_PREQ: s_d.st = ST_PCAP;
            ST_PCAP: begin
                s_d.word = ram_rdata;
                s_d.st   = ST_SEND;
            end
            ST_SEND: begin
                if (out_ready) begin
                    if (!is_fcs) s_d.crc = crc_nx;
                    if (s_q.idx == last_idx) begin
                        s_d.st = ST_IDLE;
                    end else begin
                        s_d.idx = s_q.idx + LEN_W'(1);
                        if (!is_fcs && lane == 2'd3 &&
                            (s_q.idx + LEN_W'(1)) < data_end) begin
                            s_d.st = ST_PREQ;
                        end
                    end
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign ram_rd      = (s_q.st == ST_HREQ) || (s_q.st == ST_PREQ);
    assign busy        = (s_q.st != ST_IDLE);
    assign hdr_valid   = s_q.hv;
    assign sig_field   = s_q.sig;
    assign htsig_field = s_q.htsig;
    assign out_valid   = (s_q.st == ST_SEND);
    assign out_data    = is_fcs ? fcs[{fsel, 3'b000} +: 8] : pay_byte;
    assign out_last    = out_valid && (s_q.idx == last_idx);
endmodule

// File: rtl/txseq_chk.sv
module txseq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       busy,
    input logic       hdr_valid,
    input logic       ram_rd,
    input logic       out_valid,
    input logic       out_ready,
    input logic [7:0] out_data,
    input logic       out_last
);
    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last));

    assert_last_ends_R5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_ready && out_last |=> !busy && !out_valid);

    assert_last_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> out_valid);

    assert_no_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !$fell(hdr_valid));

    assert_read_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ram_rd |-> busy && !out_valid);

    assert_hdr_first_R10: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> hdr_valid);
endmodule

bind txbuf_byte_seq txseq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .hdr_valid (hdr_valid),
    .ram_rd    (ram_rd),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .out_last  (out_last)
);

// File: tb/sim_txbuf_byte_seq.sv
`timescale 1ns/1ps
module sim_txbuf_byte_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        mode_ht = 1'b0;
    logic [11:0] pay_len = '0;
    logic [23:0] cfg_word = '0;
    logic [63:0] ts_value = '0;
    logic        ram_rd;
    logic [13:0] ram_addr;
    logic [31:0] ram_rdata = '0;
    logic        busy, hdr_valid, out_valid, out_last;
    logic [23:0] sig_field;
    logic [47:0] htsig_field;
    logic [7:0]  out_data;
    logic        out_ready = 1'b0;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    logic [31:0] salt = 32'h1234_5678;

    logic [7:0] exp_b [0:1023];
    string      exp_t [0:1023];

    always #2.5 clk = ~clk;

    txbuf_byte_seq u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .mode_ht(mode_ht),
        .pay_len(pay_len), .cfg_word(cfg_word), .ts_value(ts_value),
        .ram_rd(ram_rd), .ram_addr(ram_addr), .ram_rdata(ram_rdata),
        .busy(busy), .hdr_valid(hdr_valid), .sig_field(sig_field),
        .htsig_field(htsig_field), .out_valid(out_valid), .out_data(out_data),
        .out_last(out_last), .out_ready(out_ready)
    );

    function automatic logic [31:0] pat(input logic [13:0] a, input logic [31:0] s);
        logic [31:0] x;
        x = {18'd0, a};
        return (x * 32'h9E37_79B1) ^ s ^ (x << 7);
    endfunction

    // RAM model: one-cycle read latency
    always @(posedge clk) begin
        if (ram_rd) ram_rdata <= pat(ram_addr, salt);
    end

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles == 190000) begin
            fails = fails + 1;
            $display("FAIL watchdog: run did not end, got %0d cycles exp < 190000", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    function automatic logic [7:0] buf_byte(input int b, input logic [3:0] idx,
                                            input logic [7:0] ofs);
        logic [9:0]  w;
        logic [31:0] d;
        w = 10'(ofs) + 10'(b / 4);
        d = pat({idx, w}, salt);
        return d[8*(b%4) +: 8];
    endfunction

    function automatic logic [31:0] crc_upd(input logic [31:0] c, input logic [7:0] v);
        logic [31:0] r;
        r = c ^ {24'd0, v};
        for (int k = 0; k < 8; k++) r = r[0] ? ((r >> 1) ^ 32'hEDB8_8320) : (r >> 1);
        return r;
    endfunction

    task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h exp %h", tag, got, exp);
        end
    endtask

    task automatic run_pkt(input logic ht, input int len, input logic [3:0] idx,
                           input logic [7:0] ofs, input logic [5:0] lo, input logic [5:0] hi,
                           input logic [63:0] ts, input int rdy_pct, input bit inject);
        logic [31:0] crc;
        logic [23:0] e_sig;
        logic [47:0] e_ht;
        logic [7:0]  v;
        logic [7:0]  hold_d;
        logic        hold_l;
        bit          hold_p;
        bit          injected;
        bit          rdy;
        int          got;
        int          cyc;
        salt = $urandom;
        crc = 32'hFFFF_FFFF;
        for (int i = 0; i < len - 4; i++) begin
            v = buf_byte(16 + i, idx, ofs);
            exp_t[i] = "R5";
            if (i >= int'(lo) && i <= int'(hi)) begin
                v = ts[8*((i - int'(lo)) % 8) +: 8];
                exp_t[i] = "R7";
            end
            exp_b[i] = v;
            crc = crc_upd(crc, v);
        end
        crc = ~crc;
        for (int j = 0; j < 4; j++) begin
            exp_b[len-4+j] = crc[8*j +: 8];
            exp_t[len-4+j] = "R6";
        end
        for (int n = 0; n < 3; n++) e_sig[8*n +: 8] = buf_byte(n, idx, ofs);
        for (int n = 0; n < 6; n++) e_ht[8*n +: 8] = ht ? buf_byte(3 + n, idx, ofs) : 8'h00;

        @(negedge clk);
        start = 1'b1; mode_ht = ht; pay_len = 12'(len);
        cfg_word = {ofs, hi, lo, idx}; ts_value = ts;
        @(negedge clk);
        // R9: inputs change after the accepted start
        start = 1'b0; mode_ht = ~ht; pay_len = 12'($urandom); cfg_word = 24'($urandom);
        ts_value = {$urandom, $urandom};
        got = 0; cyc = 0; hold_p = 0; injected = 0;
        while (got < len && cyc < 20000) begin
            if (hold_p) begin
                chk("R8 hold valid", 64'(out_valid), 64'd1);
                chk("R8 hold data", 64'({out_last, out_data}), 64'({hold_l, hold_d}));
                hold_p = 0;
            end
            if (ram_rd) chk("R2 buffer index", 64'(ram_addr[13:10]), 64'(idx));
            if (inject && !injected && got == len / 2) begin
                start = 1'b1; injected = 1;
            end else begin
                start = 1'b0;
            end
            rdy = ($urandom % 100) < rdy_pct;
            out_ready = rdy;
            if (out_valid) begin
                if (rdy) begin
                    chk(exp_t[got], 64'(out_data), 64'(exp_b[got]));
                    chk("R5 last flag", 64'(out_last), 64'(got == len - 1));
                    got++;
                end else begin
                    hold_p = 1; hold_d = out_data; hold_l = out_last;
                end
            end
            @(negedge clk);
            cyc++;
        end
        start = 1'b0; out_ready = 1'b0;
        chk("R5 byte count", 64'(got), 64'(len));
        chk(ht ? "R4 sig" : "R3 sig", 64'(sig_field), 64'(e_sig));
        chk(ht ? "R4 htsig" : "R3 htsig", 64'(htsig_field), 64'(e_ht));
        chk("R10 hdr_valid held", 64'(hdr_valid), 64'd1);
        repeat (4) @(negedge clk);
        chk("R9 no restart", 64'({busy, out_valid}), 64'd0);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        chk("R1 reset outputs", 64'({busy, hdr_valid, out_valid, out_last, ram_rd}), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 idle after reset", 64'({busy, hdr_valid, out_valid, ram_rd}), 64'd0);

        // check bytes only: CRC of nothing is zero
        run_pkt(1'b0, 4, 4'd0, 8'd0, 6'd32, 6'd31, 64'h0, 100, 0);
        run_pkt(1'b1, 4, 4'd3, 8'd9, 6'd0, 6'd3, 64'hFFEE_DDCC_BBAA_9988, 60, 0);
        // single-byte window at the first payload byte
        run_pkt(1'b0, 20, 4'd15, 8'd255, 6'd0, 6'd0, 64'h0102_0304_0506_0708, 100, 0);
        // window wider than the timestamp: wraps mod 8
        run_pkt(1'b1, 64, 4'd7, 8'd17, 6'd5, 6'd25, 64'hA1B2_C3D4_E5F6_0718, 70, 0);
        // window running into the check bytes
        run_pkt(1'b0, 30, 4'd2, 8'd40, 6'd22, 6'd40, 64'h1122_3344_5566_7788, 50, 0);
        // empty window, low ready density, start injected mid-packet
        run_pkt(1'b1, 41, 4'd9, 8'd3, 6'd32, 6'd31, 64'hDEAD_BEEF_0BAD_F00D, 30, 1);
        run_pkt(1'b0, 101, 4'd1, 8'd128, 6'd12, 6'd11, 64'h0, 100, 1);

        for (int t = 0; t < 40; t++) begin
            run_pkt(1'($urandom), 4 + int'($urandom % 297), 4'($urandom), 8'($urandom),
                    6'($urandom), 6'($urandom), {$urandom, $urandom},
                    20 + int'($urandom % 81), ($urandom % 4) == 0);
        end

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        process::self().srandom(32'd2024);
    end
endmodule